// File: doc/BRIEF.md
# Interleaved Bank Memory Controller

This block sits in front of a word-addressed main memory that is divided into a number of interleaved banks. It takes at most one request per clock (a read or a write of one 64-bit word at a 24-bit word address) and steers it to the bank named by the low address bits. Consecutive addresses therefore fall in different banks, so a stream of sequential accesses keeps several banks working at once. Each bank has a fixed cycle time. While a bank is still cycling, a new request to it is held off by dropping `req_ready`.

Every stored word carries one even-parity check bit per byte. The check bits are generated on write and verified on read. A mismatch in any byte raises a flag that travels with the read data. The configured capacity is a quarter, half or full size, selected by a parameter. A request above that capacity is answered with a range error and never reaches a bank. Reads and range errors answer with a fixed latency, so responses always leave in the order the requests were taken. For diagnostics, a per-byte mask can invert the check bits as they are written.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: The bank index is `req_addr[3:0]` and the word within the bank is given by the address bits above it. Requests to distinct banks issued on consecutive cycles are all accepted without a stall.
- R2: After a bank accepts an access, `req_ready` is low for an in-range request to that same bank on the next 3 cycles, and such a request is accepted on the 4th cycle after the first.
- R3: A request to an idle bank, or any out-of-range request, sees `req_ready` high in the same cycle it is presented.
- R4: A read or out-of-range request accepted in clock cycle n produces `rsp_valid` high for exactly one cycle, in cycle n+2.
- R5: Read responses come back in request order and carry the data most recently written to that address.
- R6: An accepted in-range write produces no response.
- R7: With the default parameters, any address at or above 512 is out of range. Such a request is accepted, gives `rsp_range_err`=1 with `rsp_rdata`=0 and `rsp_parity_err`=0, writes nothing and leaves its bank idle.
- R8: The check bit of byte i is the XOR of data bits [8i+7:8i], XORed on write with `req_chk_flip[i]`. A read whose stored check bits differ from the recomputed ones sets `rsp_parity_err`, and its data is still returned unchanged. A clean word reads with `rsp_parity_err`=0.
- R9: During reset and on the cycle after it, `rsp_valid` and both error flags are low, and all banks are idle, so `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is presented |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Word address |
| req_wdata | input | 64 | Write data |
| req_chk_flip | input | 8 | Per-byte inversion mask applied to the generated check bits on write |
| req_ready | output | 1 | The presented request is taken at this clock edge |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 64 | Read data (zero on a range error) |
| rsp_parity_err | output | 1 | Check-bit mismatch on the returned word |
| rsp_range_err | output | 1 | The request was above the configured capacity |

## Verification
The bench fills every word by sweeping the banks in order, which exposes any stall on a bank that should be free. It then issues a long pseudo-random mix in which same-bank collisions cause stalls of between zero and three cycles. A counter that is off by one would show up as a stall count or a ready level that differs from the reference model. An out-of-range write is sent to an address whose low bits alias word 0, followed at once by a request to the same bank. A design that truncated the address or let the rejected request hold the bank would either corrupt word 0 or stall that request. Check-bit masks of one byte and of all bytes are written and read back, which catches a parity flag that is wrong in polarity, ignores some bytes or corrupts the data.

// File: rtl/ilv_pkg.sv
// ilv_pkg: types and helpers shared by the interleaved bank controller.
// Assumes capacity steps are quarter, half and full of a power-of-two size.
package ilv_pkg;

    typedef enum logic [1:0] {
        CAP_QUARTER = 2'd0,
        CAP_HALF    = 2'd1,
        CAP_FULL    = 2'd2
    } cap_sel_e;

    // log2 of the configured word count for a given full-size log2
    function automatic int cap_log2(int full_log2, cap_sel_e sel);
        return full_log2 - 2 + int'(sel);
    endfunction

endpackage

// File: rtl/ilv_chk_gen.sv
// ilv_chk_gen: computes one even-parity check bit per byte of a data word.
// Assumes DATA_W is a multiple of 8. Purely combinational.
module ilv_chk_gen #(
    parameter  int DATA_W = 64,
    localparam int CHK_W  = DATA_W / 8
) (
    input  logic [DATA_W-1:0] data,
    output logic [CHK_W-1:0]  chk
);

    genvar i;
    generate
        for (i = 0; i < CHK_W; i++) begin : g_byte
            // check bit i covers byte i
            assign chk[i] = ^data[8*i +: 8];
        end
    endgenerate

endmodule

// File: rtl/ilv_bank_timer.sv
// ilv_bank_timer: one down-counter per bank that marks the bank busy for
// BUSY_CYC clocks from the edge that starts an access.
// Assumes start is only raised for a bank that is currently idle.
module ilv_bank_timer #(
    parameter  int NUM_BANKS = 16,
    parameter  int BUSY_CYC  = 4,
    localparam int BANK_W    = $clog2(NUM_BANKS),
    localparam int CNT_W     = $clog2(BUSY_CYC + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [BANK_W-1:0]    start_bank,
    output logic [NUM_BANKS-1:0] busy
);

    genvar b;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic [CNT_W-1:0] cnt;

            // load on a new access, otherwise count down to idle
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (start && (start_bank == BANK_W'(b))) begin
                    cnt <= CNT_W'(BUSY_CYC - 1);
                end else if (cnt != '0) begin
                    cnt <= cnt - 1'b1;
                end
            end

            assign busy[b] = (cnt != '0);
        end
    endgenerate

endmodule

// File: rtl/ilv_bank_array.sv
// ilv_bank_array: behavioural storage for one bank, one port, registered
// read. Assumes at most one of wr_en / rd_en per cycle; contents are not reset.
module ilv_bank_array #(
    parameter  int DEPTH  = 32,
    parameter  int WORD_W = 72,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wr_word,
    output logic [WORD_W-1:0] rd_word
);

    logic [WORD_W-1:0] mem [DEPTH];

    // write the word or capture the addressed word for the read path
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[idx] <= wr_word;
        end
        if (rd_en) begin
            rd_word <= mem[idx];
        end
    end

endmodule

// File: rtl/ilv_mem_ctrl.sv
// ilv_mem_ctrl: interleaved multi-bank memory controller.
// Steers one request per clock to the bank named by the low address bits,
// stalls requests to banks still cycling, stores per-byte check bits and
// returns reads and range errors two cycles after acceptance, in order.
// Assumes a single requester and word addressing.
module ilv_mem_ctrl #(
    parameter int               ADDR_W    = 24,
    parameter int               DATA_W    = 64,
    parameter int               NUM_BANKS = 16,
    parameter int               BUSY_CYC  = 4,
    parameter int               FULL_LOG2 = 10,
    parameter ilv_pkg::cap_sel_e CAP_SEL  = ilv_pkg::CAP_HALF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_chk_flip,
    output logic                  req_ready,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic                  rsp_parity_err,
    output logic                  rsp_range_err
);

    localparam int BANK_W     = $clog2(NUM_BANKS);
    localparam int CAP_LOG2   = ilv_pkg::cap_log2(FULL_LOG2, CAP_SEL);
    localparam int BANK_DEPTH = (1 << CAP_LOG2) / NUM_BANKS;
    localparam int OFF_W      = CAP_LOG2 - BANK_W;
    localparam int CHK_W      = DATA_W / 8;
    localparam int STORE_W    = DATA_W + CHK_W;

    logic [BANK_W-1:0]    req_bank;
    logic [OFF_W-1:0]     req_off;
    logic                 req_oor;
    logic [NUM_BANKS-1:0] bank_busy;
    logic                 accept;
    logic                 take_bank;
    logic [CHK_W-1:0]     wr_chk;
    logic [STORE_W-1:0]   wr_word;
    logic [STORE_W-1:0]   bank_rd [NUM_BANKS];

    logic                 s1_valid;
    logic                 s1_oor;
    logic [BANK_W-1:0]    s1_bank;
    logic [STORE_W-1:0]   s1_word;
    logic [DATA_W-1:0]    s1_data;
    logic [CHK_W-1:0]     s1_chk;
    logic [CHK_W-1:0]     rd_chk;

    // address decode: bank select, in-bank word, capacity check
    assign req_bank  = req_addr[BANK_W-1:0];
    assign req_off   = req_addr[CAP_LOG2-1:BANK_W];
    assign req_oor   = |req_addr[ADDR_W-1:CAP_LOG2];

    // flow control: range errors never wait, bank accesses wait for idle
    assign req_ready = req_oor || !bank_busy[req_bank];
    assign accept    = req_valid && req_ready;
    assign take_bank = accept && !req_oor;

    ilv_bank_timer #(
        .NUM_BANKS (NUM_BANKS),
        .BUSY_CYC  (BUSY_CYC)
    ) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (take_bank),
        .start_bank (req_bank),
        .busy       (bank_busy)
    );

    ilv_chk_gen #(.DATA_W(DATA_W)) i_wr_chk (
        .data (req_wdata),
        .chk  (wr_chk)
    );

    assign wr_word = {wr_chk ^ req_chk_flip, req_wdata};

    genvar b;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic sel;
            assign sel = take_bank && (req_bank == BANK_W'(b));

            ilv_bank_array #(
                .DEPTH  (BANK_DEPTH),
                .WORD_W (STORE_W)
            ) i_array (
                .clk     (clk),
                .wr_en   (sel && req_write),
                .rd_en   (sel && !req_write),
                .idx     (req_off),
                .wr_word (wr_word),
                .rd_word (bank_rd[b])
            );
        end
    endgenerate

    // stage 1: remember which accepted requests owe a response and from where
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_oor   <= 1'b0;
            s1_bank  <= '0;
        end else begin
            s1_valid <= accept && (!req_write || req_oor);
            s1_oor   <= accept && req_oor;
            s1_bank  <= req_bank;
        end
    end

    assign s1_word = bank_rd[s1_bank];
    assign s1_data = s1_word[DATA_W-1:0];
    assign s1_chk  = s1_word[STORE_W-1:DATA_W];

    ilv_chk_gen #(.DATA_W(DATA_W)) i_rd_chk (
        .data (s1_data),
        .chk  (rd_chk)
    );

    // stage 2: register the response, data and error flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_rdata      <= '0;
            rsp_parity_err <= 1'b0;
            rsp_range_err  <= 1'b0;
        end else begin
            rsp_valid      <= s1_valid;
            rsp_range_err  <= s1_valid && s1_oor;
            rsp_parity_err <= s1_valid && !s1_oor && (rd_chk != s1_chk);
            rsp_rdata      <= (s1_valid && !s1_oor) ? s1_data : '0;
        end
    end

endmodule

// File: rtl/ilv_mem_ctrl_chk.sv
// ilv_mem_ctrl_chk: protocol checker for ilv_mem_ctrl, attached by bind.
// Assumes the same parameters as the controller it watches.
module ilv_mem_ctrl_chk #(
    parameter int ADDR_W   = 24,
    parameter int DATA_W   = 64,
    parameter int BANK_W   = 4,
    parameter int CAP_LOG2 = 9,
    parameter int BUSY_CYC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rsp_parity_err,
    input logic              rsp_range_err
);

    logic              above_cap;
    logic              fire;
    logic [BANK_W-1:0] prev_bank;

    assign above_cap = |req_addr[ADDR_W-1:CAP_LOG2];
    assign fire      = req_valid && req_ready;

    // track the bank index seen on the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) prev_bank <= '0;
        else        prev_bank <= req_addr[BANK_W-1:0];
    end

    p_reset_quiet_r9: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && !rsp_parity_err && !rsp_range_err));

    p_answer_two_later_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (!req_write || above_cap)) |-> ##2 rsp_valid);

    p_write_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && req_write && !above_cap) |-> ##2 !rsp_valid);

    p_range_never_waits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && above_cap) |-> req_ready);

    p_range_rsp_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_range_err) |-> ((rsp_rdata == '0) && !rsp_parity_err));

    p_flags_need_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_parity_err || rsp_range_err) |-> rsp_valid);

    generate
        if (BUSY_CYC > 1) begin : g_busy
            p_bank_busy_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (fire && !above_cap) |=>
                !(req_valid && !above_cap && (req_addr[BANK_W-1:0] == prev_bank) && req_ready));
        end
    endgenerate

endmodule

bind ilv_mem_ctrl ilv_mem_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .BANK_W   (BANK_W),
    .CAP_LOG2 (CAP_LOG2),
    .BUSY_CYC (BUSY_CYC)
) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .req_addr       (req_addr),
    .req_ready      (req_ready),
    .rsp_valid      (rsp_valid),
    .rsp_rdata      (rsp_rdata),
    .rsp_parity_err (rsp_parity_err),
    .rsp_range_err  (rsp_range_err)
);

// File: tb/test_ilv_mem_ctrl.sv
// test_ilv_mem_ctrl: cycle-by-cycle reference model of the controller,
// compared with the outputs on every clock.
module test_ilv_mem_ctrl;

    localparam int NB   = 16;
    localparam int BUSY = 4;
    localparam int CAP  = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [7:0]  req_chk_flip = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        rsp_parity_err;
    logic        rsp_range_err;

    always #10 clk = ~clk;

    ilv_mem_ctrl #(
        .ADDR_W    (24),
        .DATA_W    (64),
        .NUM_BANKS (NB),
        .BUSY_CYC  (BUSY),
        .FULL_LOG2 (10),
        .CAP_SEL   (ilv_pkg::CAP_HALF)
    ) i_ilv_mem_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_write      (req_write),
        .req_addr       (req_addr),
        .req_wdata      (req_wdata),
        .req_chk_flip   (req_chk_flip),
        .req_ready      (req_ready),
        .rsp_valid      (rsp_valid),
        .rsp_rdata      (rsp_rdata),
        .rsp_parity_err (rsp_parity_err),
        .rsp_range_err  (rsp_range_err)
    );

    typedef struct {
        int          due;
        bit          err;
        bit          perr;
        logic [63:0] data;
    } exp_t;

    int          checks = 0;
    int          fails  = 0;
    int          cyc    = 0;
    exp_t        expq[$];
    int          busy[NB];
    logic [63:0] mdata[int];
    logic [7:0]  mflip[int];

    task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] pat(int a, int k);
        logic [31:0] x;
        x = 32'(a) * 32'h9E37_79B9 + 32'(k);
        return {x, ~x ^ 32'(a)};
    endfunction

    // one clock: drive, check ready, advance the model, check the response
    task automatic step(bit v, bit w, int a, logic [63:0] d, logic [7:0] f, output bit acc);
        bit   oor;
        bit   erdy;
        bit   ev;
        int   b;
        exp_t e;
        req_valid    = v;
        req_write    = w;
        req_addr     = a[23:0];
        req_wdata    = d;
        req_chk_flip = f;
        #2;
        oor  = (a >= CAP);
        b    = a % NB;
        erdy = oor || (busy[b] == 0);
        if (v)
            check(req_ready === erdy, oor ? "R7" : (busy[b] != 0 ? "R2" : "R3"),
                  "req_ready", 64'(req_ready), 64'(erdy));
        @(posedge clk);
        acc = v && erdy;
        cyc++;
        for (int i = 0; i < NB; i++) if (busy[i] > 0) busy[i]--;
        if (acc) begin
            if (oor) begin
                expq.push_back('{cyc + 1, 1'b1, 1'b0, 64'h0});
            end else begin
                busy[b] = BUSY - 1;
                if (w) begin
                    mdata[a] = d;
                    mflip[a] = f;
                end else begin
                    expq.push_back('{cyc + 1, 1'b0, mflip[a] != 8'h0, mdata[a]});
                end
            end
        end
        @(negedge clk);
        ev = (expq.size() > 0) && (expq[0].due == cyc);
        check(rsp_valid === ev, ev ? "R4" : "R6", "rsp_valid", 64'(rsp_valid), 64'(ev));
        if (ev) begin
            e = expq.pop_front();
            if (rsp_valid === 1'b1) begin
                check(rsp_range_err === e.err, "R7", "rsp_range_err", 64'(rsp_range_err), 64'(e.err));
                check(rsp_parity_err === e.perr, "R8", "rsp_parity_err", 64'(rsp_parity_err), 64'(e.perr));
                check(rsp_rdata === e.data, e.err ? "R7" : "R5", "rsp_rdata", rsp_rdata, e.data);
            end
        end
    endtask

    task automatic issue(bit w, int a, logic [63:0] d, logic [7:0] f, output int stalls);
        bit acc;
        stalls = 0;
        do begin
            step(1'b1, w, a, d, f, acc);
            if (!acc) stalls++;
        end while (!acc && stalls < 20);
    endtask

    task automatic idle(int n);
        bit acc;
        repeat (n) step(1'b0, 1'b0, 0, 64'h0, 8'h0, acc);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R4 watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int          s;
        int          tot;
        logic [31:0] st;
        for (int i = 0; i < NB; i++) busy[i] = 0;

        // R9: reset state
        repeat (3) @(negedge clk);
        #2;
        check(req_ready === 1'b1, "R9", "req_ready in reset", 64'(req_ready), 64'h1);
        check(rsp_valid === 1'b0, "R9", "rsp_valid in reset", 64'(rsp_valid), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        check(rsp_valid === 1'b0 && rsp_range_err === 1'b0, "R9", "rsp after reset",
              64'(rsp_valid), 64'h0);

        // R1: fill every word, banks in order, no stalls expected
        tot = 0;
        for (int a = 0; a < CAP; a++) begin
            issue(1'b1, a, pat(a, 0), 8'h0, s);
            tot += s;
        end
        check(tot == 0, "R1", "stalls on sequential writes", 64'(tot), 64'h0);
        tot = 0;
        for (int a = 0; a < 48; a++) begin
            issue(1'b0, a, 64'h0, 8'h0, s);
            tot += s;
        end
        check(tot == 0, "R1", "stalls on sequential reads", 64'(tot), 64'h0);
        idle(4);

        // R2: back-to-back same-bank accesses stall BUSY-1 cycles
        issue(1'b1, 32, pat(32, 1), 8'h0, s);
        issue(1'b1, 48, pat(48, 1), 8'h0, s);
        check(s == BUSY - 1, "R2", "write-write same bank stalls", 64'(s), 64'(BUSY - 1));
        issue(1'b0, 32, 64'h0, 8'h0, s);
        check(s == BUSY - 1, "R2", "write-read same bank stalls", 64'(s), 64'(BUSY - 1));
        issue(1'b0, 48, 64'h0, 8'h0, s);
        check(s == BUSY - 1, "R2", "read-read same bank stalls", 64'(s), 64'(BUSY - 1));
        idle(4);

        // R3: idle bank accepted at once
        issue(1'b0, 100, 64'h0, 8'h0, s);
        check(s == 0, "R3", "idle bank stalls", 64'(s), 64'h0);
        idle(4);

        // R7: out-of-range requests, aliasing onto word 0 and bank 0
        issue(1'b1, 512, 64'hDEAD_BEEF_0BAD_F00D, 8'h0, s);
        issue(1'b0, 0, 64'h0, 8'h0, s);
        check(s == 0, "R7", "bank left idle after range error", 64'(s), 64'h0);
        issue(1'b0, 24'hFFFFFF, 64'h0, 8'h0, s);
        issue(1'b0, 513, 64'h0, 8'h0, s);
        issue(1'b0, 1, 64'h0, 8'h0, s);
        check(s == 0, "R7", "bank 1 idle after range error", 64'(s), 64'h0);
        idle(4);

        // R8: corrupted and clean check bits
        issue(1'b1, 5, pat(5, 7), 8'h10, s);
        idle(4);
        issue(1'b0, 5, 64'h0, 8'h0, s);
        issue(1'b1, 6, pat(6, 7), 8'hFF, s);
        idle(4);
        issue(1'b0, 6, 64'h0, 8'h0, s);
        issue(1'b1, 5, pat(5, 8), 8'h0, s);
        idle(4);
        issue(1'b0, 5, 64'h0, 8'h0, s);
        idle(4);

        // R5: pseudo-random mix of reads and writes with bank collisions
        st = 32'h1234_5678;
        for (int k = 0; k < 800; k++) begin
            st ^= st << 13;
            st ^= st >> 17;
            st ^= st << 5;
            issue(st[20], int'(st[8:0]), pat(int'(st[8:0]), k), 8'h0, s);
            if (st[25:24] == 2'b00) idle(1);
        end
        idle(6);
        check(expq.size() == 0, "R5", "responses left outstanding", 64'(expq.size()), 64'h0);

        finish_run();
    end

endmodule